// File: doc/BRIEF.md
# Triggered Multi-Waveform Playback Engine

This block keeps a set of sample waveforms in on-chip dual-port storage, each filed under a small numeric identifier with its own length, and streams one of them to a DAC sample port on command. A host feeds load commands through a word-wide command port. Each command names the identifier, gives the point count, and then supplies the points. A separate trigger port picks the identifier to play and starts output.

Once started, the chosen waveform repeats without gaps at a rate set by a 32-bit phase increment. The stream runs until a stop request or a new trigger arrives. New waveforms can be loaded while another one plays, because the write side and the read side of the storage are independent. The stored regions are handed out in order from a running allocation pointer. A waveform only becomes visible to the trigger port once its last point has been written.

Top module: `wave_player`

## Requirements
- R1: While reset is applied and after it is released, `dac_valid`, `dac_data`, `trig_err` and `load_rej` are all zero.
- R2: A load command occupies consecutive `cmd_valid` words. The first word carries the identifier in bits [2:0], the second carries the point count, and then that many sample words follow. Playback of that identifier reproduces those words in the order they were written.
- R3: After the clock edge that accepts a trigger, `dac_valid` is still low. After the next edge, `dac_valid` is high and `dac_data` holds point 0 of the selected wave.
- R4: During playback, a new sample is presented every 2^32/`rate` clock cycles, according to the carry of a 32-bit phase accumulator. `dac_valid` is high for one cycle per sample, and `dac_data` holds its value between samples.
- R5: After the last point of the playing wave, the next sample is point 0 of the same wave. Playback continues indefinitely.
- R6: A trigger naming an identifier that has never been loaded, or whose length is zero, leaves the output and any running playback untouched. `trig_err` is high for exactly the one cycle after the edge that samples that trigger.
- R7: `stop` ends playback at the edge that samples it. From that edge on, `dac_data` is zero and `dac_valid` is low until a new trigger. A trigger presented in the same cycle as `stop` is discarded and does not raise `trig_err`.
- R8: A valid trigger during playback abandons the current wave. Output restarts from point 0 of the newly named wave, with the same timing as in R3.
- R9: A load command naming the identifier that is playing is rejected. `load_rej` is high for the one cycle after the edge that takes the count word. The sample words that follow are discarded, and the playing data is not changed.
- R10: A load command naming another identifier is accepted during playback. It does not delay or alter the running stream, and the newly loaded wave plays correctly afterwards.
- R11: Each accepted load takes the next contiguous region of storage. A count larger than the remaining space is rejected with the same one-cycle `load_rej` pulse, and the identifier keeps its earlier state. A count that fills the space exactly is accepted.
- R12: A load with a count of zero is accepted, with no sample words. After it, the identifier counts as unloaded for triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | A command word is present on `cmd_data` |
| cmd_data | input | 16 | Command word: identifier, point count or sample |
| trig | input | 1 | Start playback of `trig_id` |
| trig_id | input | 3 | Identifier to play on `trig` |
| stop | input | 1 | End playback and zero the output |
| rate | input | 32 | Phase increment added every cycle; each carry is one output sample |
| dac_data | output | 16 | Current output sample |
| dac_valid | output | 1 | One-cycle strobe for each new output sample |
| trig_err | output | 1 | One-cycle flag for a trigger on an unloaded or empty wave |
| load_rej | output | 1 | One-cycle flag for a rejected load command |

## Verification
The hardest situations to reach from the ports are the ones where two activities overlap in time. One is a load command whose words arrive while a stream is running, aimed at the playing identifier or at another one. The other is a retrigger that lands just before the next sample fetch. The stimulus computes, from the trigger edge and the sample period, exactly how many cycles of slack each stream has. It then places the load words, invalid triggers and retriggers inside that window, so that any change to sample spacing or content is seen by the scoreboard. The allocation boundary is reached by loading one long wave whose count matches the remaining space exactly, and then offering a single point more.

// File: rtl/wave_player_pkg.sv
`timescale 1ns/1ps
package wave_player_pkg;

  // Command-port parser states
  typedef enum logic [1:0] {
    LD_HDR  = 2'd0,   // expecting the identifier word
    LD_CNT  = 2'd1,   // expecting the point count word
    LD_DATA = 2'd2,   // storing sample words
    LD_SKIP = 2'd3    // discarding sample words of a rejected command
  } ld_state_e;

endpackage

// File: rtl/wp_sample_ram.sv
`timescale 1ns/1ps
module wp_sample_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // Independent write and registered read ports
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
    if (re) rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/wp_loader.sv
`timescale 1ns/1ps
module wp_loader
  import wave_player_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              play_active,
  input  logic [ID_W-1:0]   play_id,
  input  logic [ID_W-1:0]   lk_id,
  output logic [ADDR_W-1:0] lk_base,
  output logic [ADDR_W:0]   lk_len,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              load_rej
);
  localparam int NUM_IDS = 1 << ID_W;
  localparam int LEN_W   = ADDR_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;

  ld_state_e         st_q, st_n;
  logic [ID_W-1:0]   id_q, id_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [DATA_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0]  alloc_q, alloc_n;
  logic              rej_q, rej_n;

  logic [ADDR_W-1:0] base_q [NUM_IDS];
  logic [LEN_W-1:0]  dlen_q [NUM_IDS];

  logic              commit;
  logic [ADDR_W-1:0] commit_base;
  logic [LEN_W-1:0]  commit_len;
  logic [LEN_W-1:0]  free_words;
  logic              busy_hit;

  assign free_words = LEN_W'(DEPTH) - alloc_q;
  assign busy_hit   = play_active && (play_id == id_q);
  assign ram_wdata  = cmd_data;
  assign ram_waddr  = alloc_q[ADDR_W-1:0] + cnt_q[ADDR_W-1:0];
  assign lk_base    = base_q[lk_id];
  assign lk_len     = dlen_q[lk_id];
  assign load_rej   = rej_q;

  // Next-state logic
  always_comb begin
    st_n        = st_q;
    id_n        = id_q;
    len_n       = len_q;
    cnt_n       = cnt_q;
    alloc_n     = alloc_q;
    rej_n       = 1'b0;
    ram_we      = 1'b0;
    commit      = 1'b0;
    commit_base = alloc_q[ADDR_W-1:0];
    commit_len  = len_q;
    if (cmd_valid) begin
      unique case (st_q)
        LD_HDR: begin
          id_n = cmd_data[ID_W-1:0];
          st_n = LD_CNT;
        end
        LD_CNT: begin
          if (busy_hit || (cmd_data > DATA_W'(free_words))) begin
            rej_n = 1'b1;
            cnt_n = cmd_data;
            st_n  = (cmd_data == '0) ? LD_HDR : LD_SKIP;
          end else if (cmd_data == '0) begin
            commit     = 1'b1;
            commit_len = '0;
            st_n       = LD_HDR;
          end else begin
            len_n = cmd_data[LEN_W-1:0];
            cnt_n = '0;
            st_n  = LD_DATA;
          end
        end
        LD_DATA: begin
          ram_we = 1'b1;
          cnt_n  = cnt_q + DATA_W'(1);
          if (cnt_q + DATA_W'(1) == DATA_W'(len_q)) begin
            commit  = 1'b1;
            alloc_n = alloc_q + len_q;
            st_n    = LD_HDR;
          end
        end
        LD_SKIP: begin
          cnt_n = cnt_q - DATA_W'(1);
          if (cnt_q == DATA_W'(1)) st_n = LD_HDR;
        end
        default: st_n = LD_HDR;
      endcase
    end
  end

  // Parser registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LD_HDR;
      id_q    <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      alloc_q <= '0;
      rej_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      id_q    <= id_n;
      len_q   <= len_n;
      cnt_q   <= cnt_n;
      alloc_q <= alloc_n;
      rej_q   <= rej_n;
    end
  end

  // Descriptor table: one enable per identifier
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_IDS; i++) begin
        base_q[i] <= '0;
        dlen_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_IDS; i++) begin
        if (commit && (id_q == ID_W'(i))) begin
          base_q[i] <= commit_base;
          dlen_q[i] <= commit_len;
        end
      end
    end
  end
endmodule

// File: rtl/wp_rate_gen.sv
`timescale 1ns/1ps
module wp_rate_gen #(
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] acc_q, acc_n;
  logic [RATE_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, rate};
  assign tick = run && !clear && sum[RATE_W];

  always_comb begin
    acc_n = acc_q;
    if (clear)    acc_n = '0;
    else if (run) acc_n = sum[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_n;
  end
endmodule

// File: rtl/wp_playback.sv
`timescale 1ns/1ps
module wp_playback #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [ID_W-1:0]   trig_id,
  input  logic              stop,
  input  logic              tick,
  output logic [ID_W-1:0]   lk_id,
  input  logic [ADDR_W-1:0] lk_base,
  input  logic [ADDR_W:0]   lk_len,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              playing,
  output logic [ID_W-1:0]   play_id,
  output logic              rate_clear,
  output logic              trig_err,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_valid
);
  localparam int LEN_W = ADDR_W + 1;

  logic              play_q, play_n;
  logic [ID_W-1:0]   id_q, id_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [LEN_W-1:0]  len_q, len_n;
  logic [LEN_W-1:0]  off_q, off_n;
  logic              pend_q, pend_n;
  logic              err_q, err_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              valid_q, valid_n;
  logic              trig_ok;

  assign lk_id     = trig_id;
  assign trig_ok   = trig && (lk_len != '0);
  assign playing   = play_q;
  assign play_id   = id_q;
  assign trig_err  = err_q;
  assign dac_data  = data_q;
  assign dac_valid = valid_q;

  // Next-state logic: stop, then a valid trigger, then rate ticks
  always_comb begin
    play_n     = play_q;
    id_n       = id_q;
    base_n     = base_q;
    len_n      = len_q;
    off_n      = off_q;
    pend_n     = 1'b0;
    err_n      = 1'b0;
    ram_re     = 1'b0;
    ram_raddr  = base_q + off_q[ADDR_W-1:0];
    rate_clear = 1'b0;
    if (stop) begin
      play_n = 1'b0;
    end else if (trig_ok) begin
      play_n     = 1'b1;
      id_n       = trig_id;
      base_n     = lk_base;
      len_n      = lk_len;
      off_n      = (lk_len == LEN_W'(1)) ? '0 : LEN_W'(1);
      ram_re     = 1'b1;
      ram_raddr  = lk_base;
      pend_n     = 1'b1;
      rate_clear = 1'b1;
    end else begin
      err_n = trig;
      if (play_q && tick) begin
        ram_re = 1'b1;
        off_n  = (off_q == len_q - LEN_W'(1)) ? '0 : off_q + LEN_W'(1);
        pend_n = 1'b1;
      end
    end
    valid_n = !stop && pend_q;
    if (stop)        data_n = '0;
    else if (pend_q) data_n = ram_rdata;
    else             data_n = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      play_q  <= 1'b0;
      id_q    <= '0;
      base_q  <= '0;
      len_q   <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      play_q  <= play_n;
      id_q    <= id_n;
      base_q  <= base_n;
      len_q   <= len_n;
      off_q   <= off_n;
      pend_q  <= pend_n;
      err_q   <= err_n;
      data_q  <= data_n;
      valid_q <= valid_n;
    end
  end
endmodule

// File: rtl/wave_player.sv
`timescale 1ns/1ps
module wave_player #(
  parameter int DATA_W = 16,
  parameter int ID_W   = 3,
  parameter int ADDR_W = 10,
  parameter int RATE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              trig,
  input  logic [ID_W-1:0]   trig_id,
  input  logic              stop,
  input  logic [RATE_W-1:0] rate,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_valid,
  output logic              trig_err,
  output logic              load_rej
);
  localparam int LEN_W = ADDR_W + 1;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic              playing;
  logic [ID_W-1:0]   play_id;
  logic [ID_W-1:0]   lk_id;
  logic [ADDR_W-1:0] lk_base;
  logic [LEN_W-1:0]  lk_len;
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;
  logic              rate_clear, tick;

  wp_loader #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_loader (
    .clk        (clk),
    .rst_n      (rst_ni),
    .cmd_valid  (cmd_valid),
    .cmd_data   (cmd_data),
    .play_active(playing),
    .play_id    (play_id),
    .lk_id      (lk_id),
    .lk_base    (lk_base),
    .lk_len     (lk_len),
    .ram_we     (ram_we),
    .ram_waddr  (ram_waddr),
    .ram_wdata  (ram_wdata),
    .load_rej   (load_rej)
  );

  wp_sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_rdata)
  );

  wp_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk  (clk),
    .rst_n(rst_ni),
    .run  (playing),
    .clear(rate_clear),
    .rate (rate),
    .tick (tick)
  );

  wp_playback #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) u_play (
    .clk       (clk),
    .rst_n     (rst_ni),
    .trig      (trig),
    .trig_id   (trig_id),
    .stop      (stop),
    .tick      (tick),
    .lk_id     (lk_id),
    .lk_base   (lk_base),
    .lk_len    (lk_len),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata),
    .playing   (playing),
    .play_id   (play_id),
    .rate_clear(rate_clear),
    .trig_err  (trig_err),
    .dac_data  (dac_data),
    .dac_valid (dac_valid)
  );
endmodule

// File: rtl/wave_player_chk.sv
`timescale 1ns/1ps
module wave_player_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              trig,
  input logic              stop,
  input logic              trig_err,
  input logic              load_rej,
  input logic              ram_we,
  input logic              rate_clear,
  input logic              playing,
  input logic              dac_valid,
  input logic [DATA_W-1:0] dac_data
);
  // R3: an accepted trigger yields a sample two edges later unless stopped
  a_r3_first_sample: assert property (@(posedge clk) disable iff (!rst_ni)
    (rate_clear ##1 !stop) |=> dac_valid);

  // R7: stop forces a silent, zeroed output
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    stop |=> (!dac_valid && (dac_data == '0)));

  // R4: output holds between sample strobes
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    (!dac_valid && !$past(stop)) |-> $stable(dac_data));

  // R4: strobes only while a wave is selected for playback
  a_r4_valid_in_play: assert property (@(posedge clk) disable iff (!rst_ni)
    dac_valid |-> playing);

  // R6: an error flag always stems from an unstopped trigger
  a_r6_err_source: assert property (@(posedge clk) disable iff (!rst_ni)
    trig_err |-> $past(trig && !stop));

  // R9: a rejected command never writes storage while flagged
  a_r9_rej_no_write: assert property (@(posedge clk) disable iff (!rst_ni)
    load_rej |-> !ram_we);
endmodule

bind wave_player wave_player_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .trig      (trig),
  .stop      (stop),
  .trig_err  (trig_err),
  .load_rej  (load_rej),
  .ram_we    (ram_we),
  .rate_clear(rate_clear),
  .playing   (playing),
  .dac_valid (dac_valid),
  .dac_data  (dac_data)
);

// File: tb/wave_player_test.sv
`timescale 1ns/1ps
module wave_player_test;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_data;
  logic        trig;
  logic [2:0]  trig_id;
  logic        stop;
  logic [31:0] rate;
  logic [15:0] dac_data;
  logic        dac_valid;
  logic        trig_err;
  logic        load_rej;

  int checks;
  int fails;
  int since;
  int restart;
  int exp_period;
  longint cyc;
  logic [15:0] exp_q[$];

  wave_player uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_data (cmd_data),
    .trig     (trig),
    .trig_id  (trig_id),
    .stop     (stop),
    .rate     (rate),
    .dac_data (dac_data),
    .dac_valid(dac_valid),
    .trig_err (trig_err),
    .load_rej (load_rej)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] smp(input int id, input int i);
    return 16'(id * 4099 + i * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: pops expected samples and checks spacing
  int seen_restart;
  bit have_last;
  longint last_cyc;
  always @(negedge clk) begin
    if (rst_n && dac_valid) begin
      if (seen_restart != restart) begin
        seen_restart = restart;
        have_last = 0;
      end
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "strobe with nothing expected", 1, 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(dac_data == e, "R2", "sample value", dac_data, e);
      end
      if (have_last)
        chk(cyc - last_cyc == exp_period, "R4", "strobe spacing", cyc - last_cyc, exp_period);
      have_last = 1;
      last_cyc  = cyc;
    end
  end

  task automatic step;
    @(posedge clk);
    #1;
    since++;
  endtask

  task automatic load_wave(input int id, input int len, input bit exp_rej, input string req);
    cmd_valid = 1'b1;
    cmd_data  = 16'(id);
    step();
    cmd_data  = 16'(len);
    step();
    chk(load_rej == exp_rej, req, "load_rej after count word", load_rej, exp_rej);
    for (int i = 0; i < len; i++) begin
      cmd_data = smp(id, i);
      step();
    end
    cmd_valid = 1'b0;
    cmd_data  = '0;
  endtask

  task automatic start_play(input int id, input int len, input int per, input int n);
    rate       = 32'(64'd4294967296 / per);
    exp_period = per;
    restart++;
    for (int i = 0; i < n; i++) exp_q.push_back(smp(id, i % len));
    trig    = 1'b1;
    trig_id = 3'(id);
    step();
    trig  = 1'b0;
    since = 0;
    chk(dac_valid == 1'b0, "R3", "no strobe right after accept", dac_valid, 0);
    step();
    chk(dac_valid == 1'b1, "R3", "strobe one clock after accept", dac_valid, 1);
    chk(dac_data == smp(id, 0), "R3", "first point", dac_data, smp(id, 0));
  endtask

  task automatic finish_play(input int per, input int n);
    repeat (per * n - 1 - since) step();
    stop = 1'b1;
    step();
    stop = 1'b0;
    chk(dac_valid == 1'b0 && dac_data == 16'h0, "R7", "output after stop", dac_data, 0);
    chk(exp_q.size() == 0, "R5", "samples left unplayed", exp_q.size(), 0);
    repeat (6) step();
    exp_q.delete();
  endtask

  task automatic bad_trig(input int id, input string req);
    trig    = 1'b1;
    trig_id = 3'(id);
    step();
    trig = 1'b0;
    chk(trig_err == 1'b1, req, "trig_err raised", trig_err, 1);
    step();
    chk(trig_err == 1'b0, req, "trig_err lasts one cycle", trig_err, 0);
  endtask

  initial begin
    #(200000 * 5);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    report();
  end

  initial begin
    checks = 0; fails = 0; since = 0; restart = 0; exp_period = 0;
    cyc = 0; seen_restart = 0; have_last = 0; last_cyc = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0;
    trig = 1'b0; trig_id = '0; stop = 1'b0; rate = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(dac_valid == 0 && dac_data == 0, "R1", "outputs in reset", dac_data, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk(dac_valid == 0 && dac_data == 0, "R1", "outputs after reset", dac_data, 0);
    chk(trig_err == 0 && load_rej == 0, "R1", "flags after reset", {trig_err, load_rej}, 0);

    // R2: three waves of different lengths
    load_wave(1, 5, 1'b0, "R2");
    load_wave(2, 3, 1'b0, "R2");
    load_wave(5, 1, 1'b0, "R2");

    // R3, R4, R5: 12 samples of a 5-point wave, period 4
    start_play(1, 5, 4, 12);
    step();
    chk(dac_valid == 0 && dac_data == smp(1, 0), "R4", "hold between strobes", dac_data, smp(1, 0));
    finish_play(4, 12);

    // R6: unloaded identifier while idle
    bad_trig(4, "R6");

    // R6: invalid trigger during playback leaves the stream intact
    start_play(2, 3, 2, 10);
    bad_trig(6, "R6");
    finish_play(2, 10);

    // R7: stop wins over a trigger in the same cycle
    trig = 1'b1; trig_id = 3'd1; stop = 1'b1;
    step();
    trig = 1'b0; stop = 1'b0;
    chk(trig_err == 1'b0, "R7", "no error for discarded trigger", trig_err, 0);
    repeat (3) step();
    chk(dac_valid == 1'b0 && dac_data == 16'h0, "R7", "no playback after stop+trigger", dac_data, 0);

    // R8: retrigger to a different wave before the fourth sample
    start_play(1, 5, 4, 3);
    repeat (9) step();
    chk(exp_q.size() == 0, "R8", "old wave consumed before retrigger", exp_q.size(), 0);
    start_play(2, 3, 4, 5);
    chk(dac_data == smp(2, 0), "R8", "restart at point 0 of new wave", dac_data, smp(2, 0));
    finish_play(4, 5);

    // R9 and R10: loads while wave 1 plays
    start_play(1, 5, 4, 8);
    load_wave(1, 3, 1'b1, "R9");
    load_wave(3, 4, 1'b0, "R10");
    finish_play(4, 8);
    start_play(3, 4, 2, 6);
    finish_play(2, 6);
    start_play(1, 5, 2, 5);
    finish_play(2, 5);

    // R12: zero-length load unloads the identifier
    load_wave(5, 0, 1'b0, "R12");
    bad_trig(5, "R12");

    // R11: fill storage exactly, then overflow by one point
    load_wave(6, 1011, 1'b0, "R11");
    load_wave(7, 1, 1'b1, "R11");
    bad_trig(7, "R11");
    start_play(6, 1011, 2, 4);
    finish_play(2, 4);

    report();
  end
endmodule